// File: doc/BRIEF.md
# Deep Sleep Power Mode Controller

This block is the power-mode state machine that takes a processor into and out of its deepest low-power state. In the Active mode it drives the clock enables for the PLL, the core, the system bus, the peripherals and the SDRAM. The enables follow a small PLL control register that software writes. A one-cycle software strobe moves the controller into deep sleep. There the PLL, core, system and SDRAM clocks all stop. Every peripheral except the real-time clock is gated off, DMA and interrupt traffic is refused, and a status pin stays high.

Deep sleep has only two ways out. A real-time-clock interrupt wakes the part into the Active mode. On that wake the PLL control flags are forced so that the part runs bypassed instead of returning to its earlier full-speed setting. An asynchronous active-low hardware reset starts a fixed-length reset sequence instead, and the sequence ends in the Active mode with the register at its defaults.

The PLL control register is `4 + MULT_W` bits wide. Bit 0 turns the PLL off, bit 1 stops the core clock, bit 2 requests power-down, and bit 3 selects PLL bypass. Bits `[MULT_W+3:4]` hold a multiplier value. Its reset value has all four flags at 0 and the multiplier at `MULT_RST` (9'h0A0 with the defaults).

Top module: `deep_sleep_ctrl`

## Requirements
- R1: While `hw_rst_n` is low, and until the fourth rising edge of `clk` after its release, the outputs are: `pll_en`=1, `rtc_clk_en`=1, `sleep_flag`=0, all other enables 0, `dma_ack`=0, `irq_out`=0, `ctl_q`=reset value. After that fourth edge the controller is in Active mode.
- R2: In Active mode, `sclk_en`, `sdram_clk_en`, `rtc_clk_en` and every `periph_en` bit are 1. `pll_en` is the inverse of `ctl_q[0]`, `cclk_en` is the inverse of `ctl_q[1]`, and `sleep_flag` is 0. `dma_ack` and `irq_out` show `dma_req` and `irq_in` as sampled at the previous edge.
- R3: A `sleep_req` sampled high in Active mode puts the controller in deep sleep after that same edge, and `pll_en`, `cclk_en` and `sclk_en` are 0 from then on.
- R4: In deep sleep, `sleep_flag` is 1, `rtc_clk_en` is 1, and `sdram_clk_en`, `periph_en`, `dma_ack` and `irq_out` are all 0.
- R5: In deep sleep, `sleep_req`, `irq_in`, `dma_req` and `ctl_we` have no effect. The controller stays in deep sleep with `ctl_q` unchanged until `rtc_irq` or reset.
- R6: `rtc_irq` sampled high in deep sleep returns the controller to Active mode after that edge. `ctl_q[3:0]` becomes 4'b1000 (only bypass set) and the multiplier field keeps its value.
- R7: A `ctl_we` sampled in Active mode loads `ctl_wdata` into `ctl_q` at that edge. Writes made during the reset sequence or deep sleep are dropped.
- R8: Reset asserted during deep sleep, even in the same cycle as `rtc_irq`, starts the reset sequence and restores the register's reset value instead of the wake value.
- R9: `rtc_irq` in Active mode has no effect on the mode or on `ctl_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst_n | input | 1 | Asynchronous active-low hardware reset |
| sleep_req | input | 1 | One-cycle software request to enter deep sleep |
| rtc_irq | input | 1 | Real-time-clock wake interrupt |
| irq_in | input | N_IRQ | Other interrupt requests |
| dma_req | input | 1 | DMA request |
| ctl_we | input | 1 | PLL control register write strobe |
| ctl_wdata | input | MULT_W+4 | PLL control register write data |
| ctl_q | output | MULT_W+4 | PLL control register contents |
| pll_en | output | 1 | PLL enable |
| cclk_en | output | 1 | Core clock enable |
| sclk_en | output | 1 | System clock enable |
| periph_en | output | N_PERIPH | Peripheral clock enables (RTC excluded) |
| rtc_clk_en | output | 1 | Real-time-clock enable |
| sdram_clk_en | output | 1 | SDRAM clock enable |
| sleep_flag | output | 1 | Deep-sleep status pin |
| dma_ack | output | 1 | DMA request accepted |
| irq_out | output | N_IRQ | Forwarded interrupts |

## Verification
The bench goes after the same-cycle clash of reset and the RTC wake. A design that let the wake win there would come out of reset with bypass set and no reset sequence. It also counts the reset sequence to the exact edge, which catches an off-by-one counter that reaches Active one cycle early or late. It writes the control register during sleep and during the reset sequence, where a missing mode gate would corrupt the wake value. It sends the RTC interrupt in Active mode, where a careless decoder would force the bypass flags.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [1:0] {
    MODE_RSTSEQ = 2'd0,
    MODE_ACTIVE = 2'd1,
    MODE_SLEEP  = 2'd2
  } pwr_mode_e;

  localparam int FLAG_W     = 4;
  localparam int BIT_PLLOFF = 0;
  localparam int BIT_STOPC  = 1;
  localparam int BIT_PDOWN  = 2;
  localparam int BIT_BYPASS = 3;
  localparam logic [FLAG_W-1:0] WAKE_FLAGS = 4'b1000;
endpackage

// File: rtl/dsc_rst_seq.sv
module dsc_rst_seq #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic seq_done
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign seq_done = (cnt_q == LAST);
endmodule

// File: rtl/dsc_mode_fsm.sv
module dsc_mode_fsm
  import dsc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      seq_done,
  input  logic      sleep_req,
  input  logic      rtc_irq,
  output pwr_mode_e mode_q,
  output pwr_mode_e mode_d,
  output logic      wake
);
  always_comb begin
    mode_d = mode_q;
    wake   = 1'b0;
    unique case (mode_q)
      MODE_RSTSEQ: if (seq_done) mode_d = MODE_ACTIVE;
      MODE_ACTIVE: if (sleep_req) mode_d = MODE_SLEEP;
      MODE_SLEEP: begin
        if (rtc_irq) begin
          mode_d = MODE_ACTIVE;
          wake   = 1'b1;
        end
      end
      default: mode_d = MODE_RSTSEQ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_RSTSEQ;
    else        mode_q <= mode_d;
  end
endmodule

// File: rtl/dsc_ctl_reg.sv
module dsc_ctl_reg
  import dsc_pkg::*;
#(
  parameter int MULT_W   = 5,
  parameter int MULT_RST = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  pwr_mode_e                  mode_q,
  input  logic                       wake,
  input  logic                       we,
  input  logic [MULT_W+FLAG_W-1:0]   wdata,
  output logic [MULT_W+FLAG_W-1:0]   ctl_q,
  output logic [MULT_W+FLAG_W-1:0]   ctl_d
);
  localparam int CTL_W = MULT_W + FLAG_W;
  localparam logic [CTL_W-1:0] CTL_RST = {MULT_W'(MULT_RST), {FLAG_W{1'b0}}};

  always_comb begin
    ctl_d = ctl_q;
    if (wake) begin
      ctl_d = {ctl_q[CTL_W-1:FLAG_W], WAKE_FLAGS};
    end else if (we && (mode_q == MODE_ACTIVE)) begin
      ctl_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= CTL_RST;
    else        ctl_q <= ctl_d;
  end
endmodule

// File: rtl/dsc_gate_out.sv
module dsc_gate_out
  import dsc_pkg::*;
#(
  parameter int N_PERIPH = 6,
  parameter int N_IRQ    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  pwr_mode_e           mode_d,
  input  logic                pll_off_d,
  input  logic                stopc_d,
  input  logic                dma_req,
  input  logic [N_IRQ-1:0]    irq_in,
  output logic                pll_en,
  output logic                cclk_en,
  output logic                sclk_en,
  output logic [N_PERIPH-1:0] periph_en,
  output logic                rtc_clk_en,
  output logic                sdram_clk_en,
  output logic                sleep_flag,
  output logic                dma_ack,
  output logic [N_IRQ-1:0]    irq_out
);
  logic run_d;
  assign run_d = (mode_d == MODE_ACTIVE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pll_en       <= 1'b1;
      cclk_en      <= 1'b0;
      sclk_en      <= 1'b0;
      sdram_clk_en <= 1'b0;
      sleep_flag   <= 1'b0;
      rtc_clk_en   <= 1'b1;
      dma_ack      <= 1'b0;
    end else begin
      rtc_clk_en   <= 1'b1;
      pll_en       <= run_d ? !pll_off_d : (mode_d == MODE_RSTSEQ);
      cclk_en      <= run_d && !stopc_d;
      sclk_en      <= run_d;
      sdram_clk_en <= run_d;
      sleep_flag   <= (mode_d == MODE_SLEEP);
      dma_ack      <= run_d && dma_req;
    end
  end

  for (genvar p = 0; p < N_PERIPH; p++) begin : g_periph
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) periph_en[p] <= 1'b0;
      else        periph_en[p] <= run_d;
    end
  end

  for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_out[i] <= 1'b0;
      else        irq_out[i] <= run_d && irq_in[i];
    end
  end
endmodule

// File: rtl/deep_sleep_ctrl.sv
module deep_sleep_ctrl
  import dsc_pkg::*;
#(
  parameter int N_PERIPH   = 6,
  parameter int N_IRQ      = 4,
  parameter int MULT_W     = 5,
  parameter int MULT_RST   = 10,
  parameter int RST_CYCLES = 4
) (
  input  logic                       clk,
  input  logic                       hw_rst_n,
  input  logic                       sleep_req,
  input  logic                       rtc_irq,
  input  logic [N_IRQ-1:0]           irq_in,
  input  logic                       dma_req,
  input  logic                       ctl_we,
  input  logic [MULT_W+FLAG_W-1:0]   ctl_wdata,
  output logic [MULT_W+FLAG_W-1:0]   ctl_q,
  output logic                       pll_en,
  output logic                       cclk_en,
  output logic                       sclk_en,
  output logic [N_PERIPH-1:0]        periph_en,
  output logic                       rtc_clk_en,
  output logic                       sdram_clk_en,
  output logic                       sleep_flag,
  output logic                       dma_ack,
  output logic [N_IRQ-1:0]           irq_out
);
  localparam int CTL_W = MULT_W + FLAG_W;

  logic            seq_done;
  logic            wake;
  pwr_mode_e       mode_q;
  pwr_mode_e       mode_d;
  logic [CTL_W-1:0] ctl_d;

  dsc_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
    .clk(clk), .rst_n(hw_rst_n), .seq_done(seq_done)
  );

  dsc_mode_fsm u_fsm (
    .clk(clk), .rst_n(hw_rst_n), .seq_done(seq_done),
    .sleep_req(sleep_req), .rtc_irq(rtc_irq),
    .mode_q(mode_q), .mode_d(mode_d), .wake(wake)
  );

  dsc_ctl_reg #(.MULT_W(MULT_W), .MULT_RST(MULT_RST)) u_ctl (
    .clk(clk), .rst_n(hw_rst_n), .mode_q(mode_q), .wake(wake),
    .we(ctl_we), .wdata(ctl_wdata), .ctl_q(ctl_q), .ctl_d(ctl_d)
  );

  dsc_gate_out #(.N_PERIPH(N_PERIPH), .N_IRQ(N_IRQ)) u_gate (
    .clk(clk), .rst_n(hw_rst_n), .mode_d(mode_d),
    .pll_off_d(ctl_d[BIT_PLLOFF]), .stopc_d(ctl_d[BIT_STOPC]),
    .dma_req(dma_req), .irq_in(irq_in),
    .pll_en(pll_en), .cclk_en(cclk_en), .sclk_en(sclk_en),
    .periph_en(periph_en), .rtc_clk_en(rtc_clk_en),
    .sdram_clk_en(sdram_clk_en), .sleep_flag(sleep_flag),
    .dma_ack(dma_ack), .irq_out(irq_out)
  );

  // Power-down and bypass flags are held for the PLL; they gate no clock here.
  logic unused_flags;
  assign unused_flags = ^{ctl_q[BIT_PDOWN], ctl_q[BIT_BYPASS]};
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
  parameter int N_PERIPH = 6,
  parameter int N_IRQ    = 4,
  parameter int CTL_W    = 9
) (
  input logic                clk,
  input logic                hw_rst_n,
  input logic                sleep_req,
  input logic                rtc_irq,
  input logic                ctl_we,
  input logic [CTL_W-1:0]    ctl_wdata,
  input logic [CTL_W-1:0]    ctl_q,
  input logic                pll_en,
  input logic                cclk_en,
  input logic                sclk_en,
  input logic [N_PERIPH-1:0] periph_en,
  input logic                rtc_clk_en,
  input logic                sdram_clk_en,
  input logic                sleep_flag,
  input logic                dma_ack,
  input logic [N_IRQ-1:0]    irq_out
);
  // sclk_en is high exactly in Active mode (R2), so it marks that mode here.
  p_entry_r3: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (sclk_en && sleep_req) |=> (sleep_flag && !pll_en && !cclk_en && !sclk_en));

  p_sleep_gate_r4: assert property (@(posedge clk) disable iff (!hw_rst_n)
    sleep_flag |-> (periph_en == '0 && rtc_clk_en && !sdram_clk_en
                    && !dma_ack && irq_out == '0 && !sclk_en));

  p_hold_r5: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (sleep_flag && !rtc_irq) |=> (sleep_flag && $stable(ctl_q)));

  p_wake_r6: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (sleep_flag && rtc_irq) |=> (!sleep_flag && sclk_en && ctl_q[3:0] == 4'b1000
                                 && ctl_q[CTL_W-1:4] == $past(ctl_q[CTL_W-1:4])));

  p_write_r7: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (sclk_en && ctl_we) |=> (ctl_q == $past(ctl_wdata)));

  p_rtc_active_r9: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (sclk_en && rtc_irq && !sleep_req && !ctl_we) |=> (sclk_en && $stable(ctl_q)));
endmodule

bind deep_sleep_ctrl dsc_checker #(
  .N_PERIPH(N_PERIPH), .N_IRQ(N_IRQ), .CTL_W(MULT_W + 4)
) chk_i (
  .clk(clk), .hw_rst_n(hw_rst_n), .sleep_req(sleep_req), .rtc_irq(rtc_irq),
  .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
  .pll_en(pll_en), .cclk_en(cclk_en), .sclk_en(sclk_en),
  .periph_en(periph_en), .rtc_clk_en(rtc_clk_en), .sdram_clk_en(sdram_clk_en),
  .sleep_flag(sleep_flag), .dma_ack(dma_ack), .irq_out(irq_out)
);

// File: tb/deep_sleep_ctrl_tb_top.sv
module deep_sleep_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [8:0] CTL_RST = 9'h0A0;

  logic       clk = 1'b0;
  logic       hw_rst_n = 1'b0;
  logic       sleep_req = 1'b0;
  logic       rtc_irq = 1'b0;
  logic [3:0] irq_in = '0;
  logic       dma_req = 1'b0;
  logic       ctl_we = 1'b0;
  logic [8:0] ctl_wdata = '0;
  logic [8:0] ctl_q;
  logic       pll_en, cclk_en, sclk_en, rtc_clk_en, sdram_clk_en, sleep_flag, dma_ack;
  logic [5:0] periph_en;
  logic [3:0] irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model: 0 reset sequence, 1 active, 2 sleep
  int         m_st;
  int         m_cnt;
  logic [8:0] m_ctl;
  logic       m_dma;
  logic [3:0] m_irq;
  string      last_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  deep_sleep_ctrl dut_i (
    .clk(clk), .hw_rst_n(hw_rst_n), .sleep_req(sleep_req), .rtc_irq(rtc_irq),
    .irq_in(irq_in), .dma_req(dma_req), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_q(ctl_q), .pll_en(pll_en), .cclk_en(cclk_en), .sclk_en(sclk_en),
    .periph_en(periph_en), .rtc_clk_en(rtc_clk_en), .sdram_clk_en(sdram_clk_en),
    .sleep_flag(sleep_flag), .dma_ack(dma_ack), .irq_out(irq_out)
  );

  function automatic logic [25:0] expect_vec(int st, logic [8:0] c, logic d, logic [3:0] q);
    logic act;
    act = (st == 1);
    return {c, act ? !c[0] : (st == 0), act && !c[1], act, {6{act}},
            1'b1, act, (st == 2), d, q};
  endfunction

  task automatic model_reset();
    m_st = 0; m_cnt = 0; m_ctl = CTL_RST; m_dma = 0; m_irq = '0;
  endtask

  task automatic model_step(string tag_in);
    int nst;
    nst = m_st;
    last_tag = tag_in;
    case (m_st)
      0: begin
        if (m_cnt == 3) nst = 1;
        else m_cnt++;
      end
      1: begin
        if (ctl_we) m_ctl = ctl_wdata;
        if (sleep_req) nst = 2;
      end
      default: if (rtc_irq) begin
        nst = 1;
        m_ctl = {m_ctl[8:4], 4'b1000};
      end
    endcase
    m_dma = (nst == 1) && dma_req;
    m_irq = (nst == 1) ? irq_in : 4'b0;
    if (tag_in == "") begin
      if (m_st == 2 && nst == 1) last_tag = "R6";
      else if (m_st == 1 && nst == 2) last_tag = "R3";
      else if (nst == 2) last_tag = "R4";
      else if (nst == 0 || m_st == 0) last_tag = "R1";
      else if (ctl_we) last_tag = "R7";
      else if (rtc_irq) last_tag = "R9";
      else last_tag = "R2";
    end
    m_st = nst;
  endtask

  task automatic compare();
    logic [25:0] got, exp;
    got = {ctl_q, pll_en, cclk_en, sclk_en, periph_en, rtc_clk_en,
           sdram_clk_en, sleep_flag, dma_ack, irq_out};
    exp = expect_vec(m_st, m_ctl, m_dma, m_irq);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", last_tag, got, exp, $time);
    end
  endtask

  // Called at a falling edge: drive, take one rising edge, check at the next fall.
  task automatic step(input bit rn, input bit rq, input bit rt, input bit we,
                      input logic [8:0] wd, input logic [3:0] iq, input bit dm,
                      input string tag);
    hw_rst_n = rn; sleep_req = rq; rtc_irq = rt; ctl_we = we;
    ctl_wdata = wd; irq_in = iq; dma_req = dm;
    if (!rn) begin
      model_reset();
      last_tag = (tag == "") ? "R1" : tag;
    end
    @(posedge clk);
    if (rn) model_step(tag);
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    model_reset();
    @(negedge clk);
    // R1: reset values, then exactly four edges of sequence
    step(0, 0, 0, 0, '0, '0, 0, "R1");
    step(1, 1, 1, 1, 9'h1FF, 4'hF, 1, "R1");
    step(1, 0, 0, 1, 9'h1FF, 4'hF, 1, "R1");
    step(1, 0, 0, 0, '0, '0, 0, "R1");
    step(1, 0, 0, 0, '0, 4'h5, 1, "R1");
    // R2: active traffic forwarded
    step(1, 0, 0, 0, '0, 4'hA, 0, "R2");
    // R7: write with PLL off and core stop
    step(1, 0, 0, 1, 9'h0F3, '0, 0, "R7");
    step(1, 0, 0, 1, 9'h0A4, '0, 0, "R7");
    // R9: RTC in active ignored
    step(1, 0, 1, 0, '0, '0, 0, "R9");
    // R3: enter sleep
    step(1, 1, 0, 0, '0, 4'hF, 1, "R3");
    // R5: everything but RTC ignored, write dropped
    step(1, 1, 0, 1, 9'h1FF, 4'hF, 1, "R5");
    step(1, 0, 0, 1, 9'h003, 4'h3, 1, "R5");
    step(1, 0, 0, 0, '0, '0, 0, "R4");
    // R6: wake forces bypass flags, keeps multiplier
    step(1, 0, 1, 0, '0, 4'h6, 1, "R6");
    step(1, 0, 0, 0, '0, '0, 0, "R6");
    // R8: reset together with RTC while sleeping
    step(1, 1, 0, 0, '0, '0, 0, "R3");
    step(0, 0, 1, 0, '0, '0, 0, "R8");
    step(1, 0, 1, 0, '0, '0, 0, "R8");
    for (int k = 0; k < 4; k++) step(1, 0, 0, 0, '0, '0, 0, "R8");

    for (int n = 0; n < 4000; n++) begin
      bit rn;
      rn = ($urandom_range(0, 199) != 0);
      step(rn, ($urandom_range(0, 7) == 0), ($urandom_range(0, 9) == 0),
           ($urandom_range(0, 3) == 0), 9'($urandom), 4'($urandom),
           1'($urandom), "");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule